// File: doc/BRIEF.md
# Display Data Channel Two-Wire Slave

This block is the slave end of a two-wire display data channel. The host is always the master and chooses the direction of each transfer. The block answers only on the fixed 8-bit address bytes A0h (write) and A1h (read). It keeps an 8-bit byte pointer into a 256-byte buffer that sits outside the block. On a write, the first data byte loads the pointer and later bytes are stored at the pointer. On a read, bytes are fetched from the pointer and shifted out. The pointer advances after every byte stored or sent, and wraps from FFh to 00h, so one transfer can move a single byte or a burst.

Both bus lines pass through a synchroniser and a glitch filter in the system clock domain before SCL edges, START and STOP are detected. Software is tied in through a one-cycle `byte_evt` pulse and a `sw_ready` input. The block holds SCL low after each stored write byte, and before each read byte is fetched, until software raises `sw_ready`. The bus pins are open-drain: a high enable pulls the line low.

The controller states are IDLE, ADDR, ADDR_ACK, WR_BYTE, WR_ACK, WAIT_SW, RD_BYTE and RD_ACK.

- From any state, STOP goes to IDLE and START goes to ADDR.
- ADDR goes to ADDR_ACK on the eighth SCL fall when the address matches, and to IDLE when it does not.
- ADDR_ACK goes to WR_BYTE (write) or WAIT_SW (read) on the next SCL fall.
- WR_BYTE goes to WR_ACK on the eighth fall.
- WR_ACK goes to WR_BYTE after the pointer byte, or to WAIT_SW after a stored byte.
- WAIT_SW goes to WR_BYTE or RD_BYTE when `sw_ready` is high.
- RD_BYTE goes to RD_ACK after eight bits.
- RD_ACK goes to WAIT_SW when the master acknowledged, or to IDLE when it did not.

Top module: `disp_twi_slave`

## Requirements
- R1: The address byte A0h is acknowledged and selects write mode.
- R2: The address byte A1h is acknowledged and selects read mode.
- R3: Any other address byte is not acknowledged. The block then drives neither SDA nor SCL and writes nothing to the buffer until the next START.
- R4: In write mode, the first data byte is acknowledged and loaded into the pointer. The loaded value appears on `buf_addr`, and no buffer write occurs.
- R5: Each later write byte gives one `buf_we` pulse, with `buf_addr` equal to the pointer and `buf_wdata` equal to the byte. The pointer then increments by one, wrapping from FFh to 00h.
- R6: The block pulls SDA low during the ninth SCL clock after every accepted address byte and every write data byte.
- R7: In read mode, the buffer byte at the pointer is sent MSB first. The pointer increments after each byte, wrapping from FFh to 00h.
- R8: A NACK from the master (SDA high in the ninth clock) ends the read. The block then releases SDA and does not drive it until the next START.
- R9: A START, including a repeated START inside a transfer, restarts address matching. Neither START nor STOP changes the pointer.
- R10: After each stored write byte, and before each read byte, the block pulses `byte_evt` for one cycle. It then holds SCL low until `sw_ready` is seen high.
- R11: A STOP at any point returns the block to idle with both lines released. An unfinished byte is discarded.
- R12: An SDA or SCL pulse shorter than FILT_LEN consecutive system-clock samples (default 3) is ignored.
- R13: During reset, both line enables, `buf_we` and `byte_evt` are low, and `buf_addr` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or data 0) |
| buf_addr | output | 8 | Buffer address (current pointer) |
| buf_wdata | output | 8 | Buffer write data |
| buf_we | output | 1 | One-cycle buffer write strobe |
| buf_rdata | input | 8 | Buffer read data for `buf_addr`, combinational |
| sw_ready | input | 1 | Software has consumed or supplied the byte |
| byte_evt | output | 1 | One-cycle pulse: byte stored or next read byte needed |

## Verification
A controller stuck in the wrong state shows up within one bit time. It appears either as a missing or extra ACK in the ninth clock, or as SCL held low with no `byte_evt` before it. A wrong pointer is visible on `buf_addr` as soon as the pointer byte is acknowledged. It also shows in the next `buf_we` or read byte, so the bench compares every write strobe against a queue of expected address and data pairs on every clock. A bad bit counter or shift path corrupts the first byte read back after a write. Filter or edge-detect faults show up as a false START taken from a short glitch.

// File: rtl/disp_twi_pkg.sv
package disp_twi_pkg;

    localparam int BYTE_W    = 8;
    localparam int PTR_W     = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_WAIT_SW,
        ST_RD_BYTE,
        ST_RD_ACK
    } twi_state_e;

endpackage

// File: rtl/twi_sync_filter.sv
module twi_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int RUN_W = $clog2(FILT_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_out;
    logic [RUN_W-1:0]       run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    assign sync_out = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= 1'b1;
            run_q <= '0;
        end else if (sync_out == dout) begin
            run_q <= '0;
        end else if (run_q == RUN_LAST) begin
            dout  <= sync_out;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R12
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> (dout == $past(sync_out)));

endmodule

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  =  scl_f & ~scl_q;
    assign scl_fall  = ~scl_f &  scl_q;
    assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
    assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;

    // R9
    cond_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_det, stop_det}));

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
    import disp_twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7 = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_f,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sw_ready,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  buf_addr,
    output logic [BYTE_W-1:0] buf_wdata,
    output logic              buf_we,
    output logic              byte_evt
);
    localparam logic [BIT_CNT_W-1:0] RX_LAST = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] TX_LAST = BIT_CNT_W'(BYTE_W - 1);

    twi_state_e           state_q, state_d;
    logic [BYTE_W-1:0]    shift_q;
    logic [BIT_CNT_W-1:0] bit_cnt_q;
    logic [PTR_W-1:0]     ptr_q;
    logic                 rd_q, have_ptr_q, stored_q, mst_ack_q;
    logic                 addr_hit;

    assign addr_hit = (shift_q[BYTE_W-1:1] == DEV_ADDR7);
    assign buf_addr = ptr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_fall && bit_cnt_q == RX_LAST)
                                 state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall)
                                 state_d = rd_q ? ST_WAIT_SW : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && bit_cnt_q == RX_LAST)
                                 state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)
                                 state_d = stored_q ? ST_WAIT_SW : ST_WR_BYTE;
                ST_WAIT_SW:  if (sw_ready)
                                 state_d = rd_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bit_cnt_q == TX_LAST)
                                 state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)
                                 state_d = mst_ack_q ? ST_WAIT_SW : ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q    <= '0;
            bit_cnt_q  <= '0;
            ptr_q      <= '0;
            rd_q       <= 1'b0;
            have_ptr_q <= 1'b0;
            stored_q   <= 1'b0;
            mst_ack_q  <= 1'b0;
            sda_oe     <= 1'b0;
            scl_oe     <= 1'b0;
            buf_we     <= 1'b0;
            buf_wdata  <= '0;
            byte_evt   <= 1'b0;
        end else begin
            buf_we   <= 1'b0;
            byte_evt <= 1'b0;
            if (buf_we) ptr_q <= ptr_q + 1'b1;
            if (stop_det || start_det) begin
                sda_oe    <= 1'b0;
                scl_oe    <= 1'b0;
                bit_cnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise) begin
                            shift_q   <= {shift_q[BYTE_W-2:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (scl_fall && bit_cnt_q == RX_LAST) begin
                            bit_cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe     <= 1'b1;
                                    rd_q       <= shift_q[0];
                                    have_ptr_q <= 1'b0;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                if (!have_ptr_q) begin
                                    ptr_q      <= shift_q;
                                    have_ptr_q <= 1'b1;
                                    stored_q   <= 1'b0;
                                end else begin
                                    buf_we    <= 1'b1;
                                    buf_wdata <= shift_q;
                                    stored_q  <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            if (rd_q) begin
                                scl_oe   <= 1'b1;
                                byte_evt <= 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            if (stored_q) begin
                                scl_oe   <= 1'b1;
                                byte_evt <= 1'b1;
                            end
                        end
                    end
                    ST_WAIT_SW: begin
                        if (sw_ready) begin
                            scl_oe    <= 1'b0;
                            bit_cnt_q <= '0;
                            if (rd_q) begin
                                shift_q <= buf_rdata;
                                sda_oe  <= ~buf_rdata[BYTE_W-1];
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            if (bit_cnt_q == TX_LAST) begin
                                sda_oe    <= 1'b0;
                                bit_cnt_q <= '0;
                            end else begin
                                shift_q   <= {shift_q[BYTE_W-2:0], 1'b0};
                                sda_oe    <= ~shift_q[BYTE_W-2];
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mst_ack_q <= ~sda_f;
                        if (scl_fall) begin
                            ptr_q <= ptr_q + 1'b1;
                            if (mst_ack_q) begin
                                scl_oe   <= 1'b1;
                                byte_evt <= 1'b1;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                        scl_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R10
    stretch_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> (state_q == ST_WAIT_SW));

    // R10
    evt_holds_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_evt |-> scl_oe);

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R9
    start_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> (ptr_q == $past(ptr_q)));

    // R11
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !sda_oe && !scl_oe));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!sda_oe && !scl_oe && !buf_we));

endmodule

// File: rtl/disp_twi_slave.sv
module disp_twi_slave
    import disp_twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7   = 7'h50,
    parameter int          SYNC_STAGES = 2,
    parameter int          FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  buf_addr,
    output logic [BYTE_W-1:0] buf_wdata,
    output logic              buf_we,
    input  logic [BYTE_W-1:0] buf_rdata,
    input  logic              sw_ready,
    output logic              byte_evt
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_w, flt_w;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_w = {scl_in, sda_in};

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        twi_sync_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_w[gi]),
            .dout (flt_w[gi])
        );
    end

    twi_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (flt_w[1]),
        .sda_f    (flt_w[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    twi_slave_fsm #(
        .DEV_ADDR7(DEV_ADDR7)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_f    (flt_w[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sw_ready (sw_ready),
        .buf_rdata(buf_rdata),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .buf_addr (buf_addr),
        .buf_wdata(buf_wdata),
        .buf_we   (buf_we),
        .byte_evt (byte_evt)
    );

endmodule

// File: tb/disp_twi_slave_tb.sv
module disp_twi_slave_tb;
    localparam int HP = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic m_scl_rel = 1'b1, m_sda_rel = 1'b1;
    logic scl_line, sda_line;
    logic scl_oe, sda_oe, buf_we, byte_evt;
    logic sw_ready = 1'b0;
    logic [7:0] buf_addr, buf_wdata, buf_rdata;

    assign scl_line = m_scl_rel & ~scl_oe;
    assign sda_line = m_sda_rel & ~sda_oe;

    disp_twi_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_we(buf_we), .buf_rdata(buf_rdata),
        .sw_ready(sw_ready), .byte_evt(byte_evt)
    );

    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];
    assign buf_rdata = mem[buf_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 13 + 7);
        end else if (buf_we) begin
            mem[buf_addr] <= buf_wdata;
        end
    end

    int tests = 0, fails = 0;
    int evt_cnt = 0, exp_evt = 0;
    bit quiet = 1'b0;
    bit done = 1'b0;
    logic [7:0] exp_ptr = 8'h00;
    logic [15:0] wq[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // reference comparison on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (buf_we) begin
                if (wq.size() == 0) chk(1'b0, "R4 unexpected write", {buf_addr, buf_wdata}, 0);
                else begin
                    logic [15:0] e;
                    e = wq.pop_front();
                    chk({buf_addr, buf_wdata} == e, "R5 write addr/data", {buf_addr, buf_wdata}, e);
                end
            end
            if (quiet) chk(!sda_oe && !scl_oe, "R3 lines quiet", {scl_oe, sda_oe}, 0);
        end
    end

    // software side of the handshake
    initial begin
        forever begin
            @(negedge clk);
            if (byte_evt) begin
                evt_cnt++;
                repeat (30) @(negedge clk);
                chk(scl_oe == 1'b1, "R10 scl held while waiting", scl_oe, 1);
                sw_ready = 1'b1;
                @(negedge clk);
                sw_ready = 1'b0;
            end
        end
    end

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_clock(output bit smp);
        repeat (HP/2) @(negedge clk);
        m_scl_rel = 1'b1;
        wait_scl_high();
        repeat (HP/2) @(negedge clk);
        smp = sda_line;
        repeat (HP/2) @(negedge clk);
        m_scl_rel = 1'b0;
        repeat (HP/2) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_rel = 1'b1;
        repeat (HP) @(negedge clk);
        m_scl_rel = 1'b1;
        wait_scl_high();
        repeat (HP) @(negedge clk);
        m_sda_rel = 1'b0;
        repeat (HP) @(negedge clk);
        m_scl_rel = 1'b0;
        repeat (HP/2) @(negedge clk);
    endtask

    task automatic m_stop();
        m_sda_rel = 1'b0;
        repeat (HP) @(negedge clk);
        m_scl_rel = 1'b1;
        wait_scl_high();
        repeat (HP) @(negedge clk);
        m_sda_rel = 1'b1;
        repeat (HP) @(negedge clk);
    endtask

    task automatic m_write_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            m_sda_rel = b[i];
            m_clock(s);
        end
        m_sda_rel = 1'b1;
        m_clock(s);
        acked = ~s;
    endtask

    task automatic m_read_byte(input bit ack, output logic [7:0] b);
        bit s;
        m_sda_rel = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            m_clock(s);
            b[i] = s;
        end
        m_sda_rel = ~ack;
        m_clock(s);
        m_sda_rel = 1'b1;
    endtask

    task automatic send_addr(input logic [7:0] a, input bit exp_ack, input string req);
        bit ak;
        m_write_byte(a, ak);
        chk(ak == exp_ack, req, ak, exp_ack);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        bit ak;
        m_write_byte(p, ak);
        chk(ak, "R6 ack on pointer byte", ak, 1);
        exp_ptr = p;
        chk(buf_addr == p, "R4 pointer loaded", buf_addr, p);
    endtask

    task automatic wr_data(input logic [7:0] d);
        bit ak;
        wq.push_back({exp_ptr, d});
        ref_mem[exp_ptr] = d;
        exp_ptr = exp_ptr + 1'b1;
        exp_evt++;
        m_write_byte(d, ak);
        chk(ak, "R6 ack on data byte", ak, 1);
    endtask

    task automatic rd_data(input bit ack);
        logic [7:0] b;
        exp_evt++;
        m_read_byte(ack, b);
        chk(b == ref_mem[exp_ptr], "R7 read byte MSB first", b, ref_mem[exp_ptr]);
        exp_ptr = exp_ptr + 1'b1;
    endtask

    initial begin
        bit s;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 13 + 7);
        repeat (10) @(negedge clk);
        // R13 reset state
        chk(scl_oe == 1'b0, "R13 scl_oe in reset", scl_oe, 0);
        chk(sda_oe == 1'b0, "R13 sda_oe in reset", sda_oe, 0);
        chk(buf_we == 1'b0, "R13 buf_we in reset", buf_we, 0);
        chk(byte_evt == 1'b0, "R13 byte_evt in reset", byte_evt, 0);
        chk(buf_addr == 8'h00, "R13 pointer in reset", buf_addr, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1 R4 R5 R6: burst write
        m_start();
        send_addr(8'hA0, 1'b1, "R1 write address ack");
        set_ptr(8'h10);
        wr_data(8'h3C);
        wr_data(8'h5A);
        wr_data(8'hC3);
        m_stop();
        chk(buf_addr == 8'h13, "R5 pointer after burst", buf_addr, 8'h13);

        // R2 R7 R8 R9: pointer set, repeated start, burst read
        m_start();
        send_addr(8'hA0, 1'b1, "R1 write address ack");
        set_ptr(8'h10);
        m_start();
        send_addr(8'hA1, 1'b1, "R2 read address ack after repeated start");
        rd_data(1'b1);
        rd_data(1'b1);
        rd_data(1'b0);
        chk(buf_addr == 8'h13, "R7 pointer after read burst", buf_addr, 8'h13);
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin
            m_clock(s);
            chk(s == 1'b1, "R8 SDA released after NACK", s, 1);
        end
        m_stop();
        quiet = 1'b0;

        // R9: pointer kept across STOP and START
        m_start();
        send_addr(8'hA1, 1'b1, "R2 read address ack");
        rd_data(1'b0);
        m_stop();
        chk(buf_addr == 8'h14, "R9 pointer kept", buf_addr, 8'h14);

        // R3: foreign addresses
        m_start();
        quiet = 1'b1;
        send_addr(8'hA2, 1'b0, "R3 foreign address nack");
        send_addr(8'h00, 1'b0, "R3 no ack after mismatch");
        m_stop();
        m_start();
        send_addr(8'h42, 1'b0, "R3 foreign address nack");
        m_stop();
        quiet = 1'b0;
        chk(buf_addr == 8'h14, "R3 pointer untouched", buf_addr, 8'h14);

        // R5 R7: wrap of the pointer
        m_start();
        send_addr(8'hA0, 1'b1, "R1 write address ack");
        set_ptr(8'hFE);
        wr_data(8'hAA);
        wr_data(8'hBB);
        wr_data(8'hCC);
        m_stop();
        chk(buf_addr == 8'h01, "R5 pointer wraps", buf_addr, 8'h01);
        m_start();
        send_addr(8'hA0, 1'b1, "R1 write address ack");
        set_ptr(8'hFF);
        m_start();
        send_addr(8'hA1, 1'b1, "R2 read address ack");
        rd_data(1'b1);
        rd_data(1'b0);
        chk(buf_addr == 8'h01, "R7 read pointer wraps", buf_addr, 8'h01);
        m_stop();

        // R11: STOP in the middle of a byte
        m_start();
        send_addr(8'hA0, 1'b1, "R1 write address ack");
        m_sda_rel = 1'b1; m_clock(s);
        m_sda_rel = 1'b0; m_clock(s);
        m_sda_rel = 1'b1; m_clock(s);
        m_stop();
        chk(!sda_oe && !scl_oe, "R11 lines released after STOP", {scl_oe, sda_oe}, 0);
        chk(buf_addr == 8'h01, "R11 partial byte discarded", buf_addr, 8'h01);
        m_start();
        send_addr(8'hA1, 1'b1, "R2 read address ack");
        rd_data(1'b0);
        m_stop();

        // R12: short SDA glitch while SCL high must not start a transfer
        quiet = 1'b1;
        @(negedge clk);
        m_sda_rel = 1'b0;
        repeat (2) @(negedge clk);
        m_sda_rel = 1'b1;
        repeat (HP) @(negedge clk);
        m_scl_rel = 1'b0;
        repeat (HP/2) @(negedge clk);
        send_addr(8'hA0, 1'b0, "R12 glitch gives no START");
        m_stop();
        quiet = 1'b0;

        repeat (50) @(negedge clk);
        chk(evt_cnt == exp_evt, "R10 byte_evt count", evt_cnt, exp_evt);
        chk(wq.size() == 0, "R5 all expected writes seen", wq.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule